// File: doc/BRIEF.md
# Receive Status Queue with Peek and Pop Reads

This block keeps a short first-in first-out queue of 32-bit receive-status words for a USB host controller. Each word is assembled from four fields supplied on the push side: a packet status code, a data PID, a byte count and a channel number. Software-facing logic reads the queue through two read selections. A peek read shows the oldest word and leaves it in place. A pop read shows the oldest word and removes it.

A level flag reports that the queue holds at least one word. A mask bit gates that flag onto an interrupt line. When a popped word carries a status code that calls for attention, the block raises a one-cycle event pulse and presents the word's channel number beside it. A push into a full queue is dropped and recorded in a sticky overflow flag. Software clears that flag by writing a one. Reads of an empty queue return zero and do not change the queue.

Top module: `rxsts_fifo`

## Requirements
- R1: A read with `rd_pop`=0 (peek) returns the oldest stored word on `rd_data` one cycle later and leaves the queue contents and order unchanged.
- R2: A read with `rd_pop`=1 (pop) returns the oldest stored word one cycle later and removes it, so words leave in the order they were pushed.
- R3: A peek or pop of an empty queue returns 32'h0000_0000, and a pop of an empty queue does not change the queue state.
- R4: The returned word holds zero in bits 31:21, the status code in bits 20:17, the data PID in bits 16:15, the byte count in bits 14:4 and the channel number in bits 3:0.
- R5: `nempty` is 1 exactly when the queue holds a word. `irq` equals `nempty` gated by a mask bit that `mask_wr` loads from `mask_din` and that resets to 0.
- R6: The queue holds DEPTH (default 8) words. A push into a full queue is dropped and sets `ovf`. `ovf` stays set until a cycle with `ovf_clr`=1, and a new overflow in that same cycle wins.
- R7: A push and a pop in the same cycle on a non-empty queue are both performed: the head is returned, the new word is appended and the word count is unchanged, including when the queue is full.
- R8: A pop that returns a word with status code 4'b0011, 4'b0101 or 4'b0111 raises `evt_pulse` for one cycle, in the cycle the word appears on `rd_data`, with `evt_chan` equal to the word's bits 3:0.
- R9: Words with status code 4'b0010 or any code other than those in R8 are stored and returned like any other, but never raise `evt_pulse`. Peek reads never raise it either.
- R10: After reset the queue is empty, and `nempty`, `irq`, `ovf`, `evt_pulse` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_vld | input | 1 | Append a word built from the push fields |
| push_sts | input | 4 | Packet status code of the pushed word |
| push_pid | input | 2 | Data PID of the pushed word (00 DATA0, 10 DATA1, 01 DATA2, 11 MDATA) |
| push_bcnt | input | 11 | Byte count of the pushed word |
| push_chan | input | 4 | Channel number of the pushed word |
| rd_en | input | 1 | Read request |
| rd_pop | input | 1 | Read selection: 0 peek, 1 pop |
| rd_data | output | 32 | Registered read result |
| evt_pulse | output | 1 | One-cycle event for a popped attention code |
| evt_chan | output | 4 | Channel number that goes with `evt_pulse` |
| nempty | output | 1 | Queue holds at least one word |
| mask_wr | input | 1 | Load the interrupt mask bit |
| mask_din | input | 1 | New mask value, 1 enables the interrupt |
| irq | output | 1 | Non-empty interrupt after masking |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| ovf | output | 1 | Sticky overflow flag |

## Verification
A push changes `nempty`, and through it `irq`, after the one clock edge that samples it. A mask write shows on `irq` after its edge, and an overflow or a clear shows on `ovf` after its edge. Read results, `evt_pulse` and `evt_chan` are registered together and appear after the edge that samples `rd_en`. The bench drives each stimulus on a falling edge, lets one rising edge pass, and samples on the next falling edge. The monitor marks a read as due when it samples `rd_en` at a rising edge. It then compares the queued expectation on the falling edge that follows, so the data and the event are always checked in the cycle they are due.

// File: rtl/rxsts_pkg.sv
package rxsts_pkg;

   localparam int STS_W  = 4;
   localparam int PID_W  = 2;
   localparam int BCNT_W = 11;
   localparam int CHAN_W = 4;
   localparam int WORD_W = 32;
   localparam int RSVD_W = WORD_W - STS_W - PID_W - BCNT_W - CHAN_W;

   // status codes carried in the packet status field
   localparam logic [STS_W-1:0] STS_IN_DATA   = 4'b0010;
   localparam logic [STS_W-1:0] STS_XFER_DONE = 4'b0011;
   localparam logic [STS_W-1:0] STS_TGL_ERR   = 4'b0101;
   localparam logic [STS_W-1:0] STS_CH_HALT   = 4'b0111;

   typedef struct packed {
      logic [RSVD_W-1:0] rsvd;
      logic [STS_W-1:0]  sts;
      logic [PID_W-1:0]  pid;
      logic [BCNT_W-1:0] bcnt;
      logic [CHAN_W-1:0] chan;
   } rxsts_word_t;

   function automatic logic sts_is_event(input logic [STS_W-1:0] code);
      return (code == STS_XFER_DONE) || (code == STS_TGL_ERR) ||
             (code == STS_CH_HALT);
   endfunction

endpackage

// File: rtl/rxsts_store.sv
module rxsts_store #(
   parameter  int DEPTH = 8,
   parameter  int W     = 32,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);

   logic [W-1:0]  mem_q [DEPTH];
   logic [AW-1:0] wptr_q, rptr_q, wptr_nx, rptr_nx;
   logic [CW-1:0] cnt_q;

   // pointer advance: free wrap for a power-of-two depth, compare otherwise
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wptr_nx = wptr_q + 1'b1;
      assign rptr_nx = rptr_q + 1'b1;
   end else begin : g_wrap
      assign wptr_nx = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      assign rptr_nx = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (wr_en) begin
         mem_q[wptr_q] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (wr_en) wptr_q <= wptr_nx;
         if (rd_en) rptr_q <= rptr_nx;
         unique case ({wr_en, rd_en})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign head  = mem_q[rptr_q];
   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CW'(DEPTH));

endmodule

// File: rtl/rxsts_evt.sv
module rxsts_evt
   import rxsts_pkg::*;
(
   input  rxsts_word_t       word_i,
   output logic              evt_o,
   output logic [CHAN_W-1:0] chan_o
);

   assign evt_o  = sts_is_event(word_i.sts);
   assign chan_o = word_i.chan;

endmodule

// File: rtl/rxsts_fifo.sv
module rxsts_fifo
   import rxsts_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                push_vld,
   input  logic [STS_W-1:0]    push_sts,
   input  logic [PID_W-1:0]    push_pid,
   input  logic [BCNT_W-1:0]   push_bcnt,
   input  logic [CHAN_W-1:0]   push_chan,
   input  logic                rd_en,
   input  logic                rd_pop,
   output logic [WORD_W-1:0]   rd_data,
   output logic                evt_pulse,
   output logic [CHAN_W-1:0]   evt_chan,
   output logic                nempty,
   input  logic                mask_wr,
   input  logic                mask_din,
   output logic                irq,
   input  logic                ovf_clr,
   output logic                ovf
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("rxsts_fifo: DEPTH must be at least 2");
   end
   if (RSVD_W < 0) begin : g_bad_layout
      $error("rxsts_fifo: status fields exceed the word width");
   end

   rxsts_word_t        push_word, head_word;
   logic               empty, full, pop_ok, push_ok;
   logic               head_evt;
   logic [CHAN_W-1:0]  head_chan;
   logic               mask_q, ovf_q, evt_q;
   logic [WORD_W-1:0]  rd_q;
   logic [CHAN_W-1:0]  chan_q;

   always_comb begin
      push_word      = '0;
      push_word.sts  = push_sts;
      push_word.pid  = push_pid;
      push_word.bcnt = push_bcnt;
      push_word.chan = push_chan;
   end

   assign pop_ok  = rd_en & rd_pop & ~empty;
   assign push_ok = push_vld & (~full | pop_ok);

   rxsts_store #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (push_ok),
      .wr_data (push_word),
      .rd_en   (pop_ok),
      .head    (head_word),
      .empty   (empty),
      .full    (full)
   );

   rxsts_evt u_evt (
      .word_i (head_word),
      .evt_o  (head_evt),
      .chan_o (head_chan)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q   <= '0;
         evt_q  <= 1'b0;
         chan_q <= '0;
      end else begin
         evt_q <= rd_en & pop_ok & head_evt;
         if (rd_en) begin
            rd_q   <= empty ? '0 : head_word;
            chan_q <= head_chan;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         if (mask_wr) mask_q <= mask_din;
         if (push_vld & ~push_ok) ovf_q <= 1'b1;
         else if (ovf_clr)        ovf_q <= 1'b0;
      end
   end

   assign rd_data   = rd_q;
   assign evt_pulse = evt_q;
   assign evt_chan  = chan_q;
   assign nempty    = ~empty;
   assign irq       = ~empty & mask_q;
   assign ovf       = ovf_q;

endmodule

// File: rtl/rxsts_fifo_chk.sv
module rxsts_fifo_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        push_vld,
   input logic        rd_en,
   input logic        rd_pop,
   input logic        ovf_clr,
   input logic [31:0] rd_data,
   input logic        evt_pulse,
   input logic [3:0]  evt_chan,
   input logic        nempty,
   input logic        irq,
   input logic        ovf
);

   p_empty_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !nempty |=> rd_data == 32'h0);

   p_empty_pop_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !nempty && !push_vld |=> !nempty);

   p_peek_keeps_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !rd_pop && nempty |=> nempty);

   p_rsvd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[31:21] == 11'h0);

   p_irq_needs_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !nempty |-> !irq);

   p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf && !ovf_clr |=> ovf);

   p_ovf_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> $past(push_vld) && $past(nempty));

   p_both_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      push_vld && rd_en && rd_pop && nempty |=> nempty && !ovf || $past(ovf));

   p_evt_from_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pulse |-> $past(rd_en && rd_pop && nempty));

   p_evt_chan_r8: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pulse |-> evt_chan == rd_data[3:0]);

   p_evt_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pulse |-> rd_data[20:17] == 4'b0011 || rd_data[20:17] == 4'b0101 ||
                    rd_data[20:17] == 4'b0111);

endmodule

bind rxsts_fifo rxsts_fifo_chk u_chk (.*);

// File: tb/tb_rxsts_fifo.sv
module tb_rxsts_fifo;

   localparam int CLK_P = 10;
   localparam int DEPTH = 8;

   typedef struct {
      logic [31:0] d;
      bit          ev;
      string       tag;
   } exp_t;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        push_vld = 0, rd_en = 0, rd_pop = 0, mask_wr = 0, mask_din = 0, ovf_clr = 0;
   logic [3:0]  push_sts = 0, push_chan = 0;
   logic [1:0]  push_pid = 0;
   logic [10:0] push_bcnt = 0;
   logic [31:0] rd_data;
   logic        evt_pulse, nempty, irq, ovf;
   logic [3:0]  evt_chan;

   int          checks = 0, failures = 0;
   logic [31:0] mq [$];
   exp_t        eq [$];
   bit          armed = 0;
   bit          done = 0;

   always #(CLK_P/2) clk = ~clk;

   rxsts_fifo #(.DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .push_vld(push_vld), .push_sts(push_sts),
      .push_pid(push_pid), .push_bcnt(push_bcnt), .push_chan(push_chan),
      .rd_en(rd_en), .rd_pop(rd_pop), .rd_data(rd_data), .evt_pulse(evt_pulse),
      .evt_chan(evt_chan), .nempty(nempty), .mask_wr(mask_wr), .mask_din(mask_din),
      .irq(irq), .ovf_clr(ovf_clr), .ovf(ovf)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(logic [3:0] s, logic [1:0] p, logic [10:0] b, logic [3:0] c);
      return {11'h0, s, p, b, c};
   endfunction

   function automatic bit is_ev(logic [31:0] w);
      return w[20:17] == 4'b0011 || w[20:17] == 4'b0101 || w[20:17] == 4'b0111;
   endfunction

   task automatic clear_in();
      push_vld = 0; rd_en = 0; rd_pop = 0; mask_wr = 0; ovf_clr = 0;
   endtask

   task automatic drive_push(logic [31:0] w);
      push_vld = 1; push_sts = w[20:17]; push_pid = w[16:15];
      push_bcnt = w[14:4]; push_chan = w[3:0];
   endtask

   // driver: a push, a read, or both in one cycle; expectations go to eq
   task automatic op(bit do_push, logic [31:0] w, bit do_rd, bit pop, string tag);
      exp_t e;
      @(negedge clk);
      if (do_push) drive_push(w);
      if (do_rd) begin
         rd_en = 1; rd_pop = pop;
         e.d = (mq.size() != 0) ? mq[0] : 32'h0;
         e.ev = pop && (mq.size() != 0) && is_ev(e.d);
         e.tag = tag;
         eq.push_back(e);
         if (pop && mq.size() != 0) void'(mq.pop_front());
      end
      if (do_push) begin
         if (mq.size() < DEPTH) mq.push_back(w);
      end
      @(posedge clk);
      #1 clear_in();
   endtask

   task automatic push(logic [31:0] w);
      op(1, w, 0, 0, "");
   endtask

   task automatic rd(bit pop, string tag);
      op(0, 32'h0, 1, pop, tag);
   endtask

   // monitor: compares the registered read result with the head of eq
   always @(posedge clk) armed <= rd_en;

   always @(negedge clk) begin
      if (armed) begin
         exp_t e;
         if (eq.size() == 0) begin
            check("monitor queue underrun", 32'h1, 32'h0);
         end else begin
            e = eq.pop_front();
            check({e.tag, " rd_data"}, rd_data, e.d);
            check({e.tag, " R8 R9 evt_pulse"}, {31'h0, evt_pulse}, {31'h0, e.ev});
            if (e.ev) check("R8 evt_chan", {28'h0, evt_chan}, {28'h0, e.d[3:0]});
         end
      end else if (rst_n) begin
         check("R9 evt_pulse without pop", {31'h0, evt_pulse}, 32'h0);
      end
   end

   task automatic status(string tag, logic act, logic exp);
      @(negedge clk);
      check(tag, {31'h0, act}, {31'h0, exp});
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] wa, wb;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10 reset state
      check("R10 nempty", {31'h0, nempty}, 32'h0);
      check("R10 irq", {31'h0, irq}, 32'h0);
      check("R10 ovf", {31'h0, ovf}, 32'h0);
      check("R10 evt_pulse", {31'h0, evt_pulse}, 32'h0);
      check("R10 rd_data", rd_data, 32'h0);

      // R3 empty reads
      rd(0, "R3 empty peek");
      rd(1, "R3 empty pop");
      status("R3 nempty after empty pop", nempty, 1'b0);

      // R4 field packing and R5 masking
      wa = mk(4'b0010, 2'b10, 11'd64, 4'd5);
      push(wa);
      status("R5 nempty after push", nempty, 1'b1);
      check("R5 irq masked at reset", {31'h0, irq}, 32'h0);
      @(negedge clk); mask_wr = 1; mask_din = 1; @(posedge clk); #1 clear_in();
      status("R5 irq unmasked", irq, 1'b1);
      rd(0, "R1 R4 peek first");
      rd(0, "R1 peek again");
      check("R1 nempty after peeks", {31'h0, nempty}, 32'h1);

      push(mk(4'b0011, 2'b00, 11'd8,    4'd9));
      push(mk(4'b0101, 2'b01, 11'd0,    4'd3));
      push(mk(4'b0111, 2'b11, 11'h7FF,  4'd15));
      push(mk(4'b0100, 2'b10, 11'd100,  4'd1));
      push(mk(4'b1111, 2'b01, 11'd7,    4'd12));
      rd(0, "R9 peek of event code head");
      for (int i = 0; i < 6; i++) rd(1, "R2 R8 R9 drain");
      status("R5 nempty after drain", nempty, 1'b0);
      check("R5 irq after drain", {31'h0, irq}, 32'h0);
      rd(1, "R3 pop after drain");

      // R6 overflow
      for (int i = 0; i < DEPTH; i++) push(mk(4'b0011, 2'(i), 11'(i * 3), 4'(i)));
      status("R6 ovf at full", ovf, 1'b0);
      push(mk(4'b0111, 2'b11, 11'd999, 4'd14));
      status("R6 ovf set", ovf, 1'b1);
      status("R6 ovf sticky", ovf, 1'b1);
      @(negedge clk); ovf_clr = 1; @(posedge clk); #1 clear_in();
      status("R6 ovf cleared", ovf, 1'b0);
      for (int i = 0; i < DEPTH; i++) rd(1, "R2 R6 drain full");
      rd(1, "R6 dropped word absent");

      // R7 push and pop together
      push(mk(4'b0010, 2'b00, 11'd11, 4'd2));
      wb = mk(4'b0101, 2'b10, 11'd22, 4'd6);
      op(1, wb, 1, 1, "R7 both non-empty");
      status("R7 nempty kept", nempty, 1'b1);
      rd(1, "R7 second word");
      status("R7 empty after", nempty, 1'b0);
      for (int i = 0; i < DEPTH; i++) push(mk(4'b0111, 2'b01, 11'(i), 4'(i + 4)));
      op(1, mk(4'b0011, 2'b11, 11'd500, 4'd10), 1, 1, "R7 both at full");
      status("R7 no ovf at full", ovf, 1'b0);
      for (int i = 0; i < DEPTH; i++) rd(1, "R7 drain after full");
      status("R7 empty after drain", nempty, 1'b0);

      // R3 pop of empty queue while pushing
      op(1, mk(4'b0011, 2'b00, 11'd33, 4'd8), 1, 1, "R3 pop ignored with push");
      rd(1, "R3 pushed word kept");

      @(negedge clk); mask_wr = 1; mask_din = 0; @(posedge clk); #1 clear_in();
      push(mk(4'b0010, 2'b00, 11'd1, 4'd1));
      status("R5 irq remasked", irq, 1'b0);
      rd(1, "R2 final pop");

      repeat (3) @(negedge clk);
      check("scoreboard empty", eq.size(), 32'h0);
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule